// File: doc/BRIEF.md
# Delta-Stream Factor Clearing Array

The block screens a stream of odd candidate values against a small set of prime factors, all at once. Candidates arrive as halved differences from the previous candidate. Each enabled factor slot holds a counter that follows the candidate's residue modulo that factor. The counter is kept in an offset form, so a divisible candidate shows up as a carry-out with an all-zero result. Each candidate takes two cycles. In the first cycle the doubled difference is added to every slot counter. In the second cycle any slot that carried gets its offset added back. Candidates that no slot rejects are sent on as halved differences. The differences of dropped candidates are folded into the next forwarded difference, so a downstream stage can rebuild absolute values.

Setup happens while the block is idle. Software writes each slot's factor, its starting residue (start value modulo factor) and an enable bit, then a start value and a square limit. An arm pulse applies one offset step that brings every counter into range, and then streaming begins. Every forwarded candidate is flagged as a definite prime when it lies below the square limit. Otherwise it needs a further pass against larger factors.

The sequencer has five states:
- IDLE: configuration is accepted. Arm moves to PREP.
- PREP: one offset step, then RUN.
- RUN: in_ready is high. An accepted difference moves to FIX.
- FIX: correction. Any hit returns to RUN. No hit moves to HOLD.
- HOLD: out_valid is high. out_ready returns to RUN.

Top module: `fcsa_sieve_array`

## Requirements
- R1: After reset the block is in IDLE, with in_ready and out_valid low. It stays there, ignoring in_valid, until cfg_arm is sampled high.
- R2: cfg_arm sampled at edge k gives one PREP cycle; in_ready is high from edge k+2 on.
- R3: A difference accepted at edge k is followed by exactly one FIX cycle, with in_ready and out_valid low. At edge k+2 the block is either in RUN or presenting an output.
- R4: Each input word is a halved difference: the candidate advances by twice in_hdelta. A candidate divisible by any enabled slot's factor is dropped, and in_ready returns after the FIX cycle.
- R5: A forwarded candidate's out_hdelta equals the sum of the halved differences accepted since the previous forwarded candidate, including its own.
- R6: out_true_prime is 1 exactly when the forwarded candidate value is strictly below the loaded square limit.
- R7: While out_valid is high and out_ready low, out_valid, out_hdelta and out_true_prime hold and in_ready stays low. The pending sum is cleared only by the handshake.
- R8: A slot written with enable 0 never rejects a candidate.
- R9: A slot is loaded with factor f and residue r (start mod f); the counter then holds r + 2^W − f. Outside the FIX cycle each enabled counter stays within [2^W − f, 2^W − 1]. Every doubled difference must be smaller than each enabled factor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_slot_we | input | 1 | Write one factor slot (IDLE only) |
| cfg_slot_idx | input | $clog2(N_SLOT) | Slot selected for write |
| cfg_factor | input | CNT_W | Prime factor of the slot |
| cfg_residue | input | CNT_W | Start value modulo factor |
| cfg_slot_on | input | 1 | Slot enable |
| cfg_limit_we | input | 1 | Write start value and square limit (IDLE only) |
| cfg_base | input | VAL_W | Start candidate value |
| cfg_square | input | VAL_W | Square limit for the prime flag |
| cfg_arm | input | 1 | Leave IDLE and start streaming |
| in_valid | input | 1 | Input difference valid |
| in_ready | output | 1 | Input difference accepted |
| in_hdelta | input | HD_W | Halved difference to next candidate |
| out_valid | output | 1 | Forwarded candidate valid |
| out_ready | input | 1 | Downstream accepts |
| out_hdelta | output | OD_W | Halved difference from previous forwarded candidate |
| out_true_prime | output | 1 | Candidate below square limit |

## Verification
On every cycle, the assertions check these relations:
- a counter outside its offset range;
- a carry that persists past the correction cycle;
- a doubled difference at or above a slot's factor;
- an accepted difference not followed by FIX;
- a hit that still produces an output;
- an output that moves or drops while stalled.

Whether the right candidates survive can only be shown by the bench's sweeps: odd candidates walked across a range that holds squares and products of the factors, with and without a disabled slot. The same applies to whether the folded differences rebuild the right values and whether the square-limit flag splits the stream at the right point.

// File: rtl/fcsa_pkg.sv
package fcsa_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_RUN,
        ST_FIX,
        ST_HOLD
    } fcsa_state_e;
endpackage

// File: rtl/fcsa_clear_unit.sv
module fcsa_clear_unit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_we,
    input  logic         ld_on,
    input  logic [W-1:0] ld_factor,
    input  logic [W-1:0] ld_residue,
    input  logic         do_prep,
    input  logic         do_add,
    input  logic         do_fix,
    input  logic [W-1:0] add_val,
    output logic         hit
);
    logic [W-1:0] cnt;
    logic [W-1:0] offs;
    logic         on;
    logic         ovf_q;
    logic         hit_q;
    logic         in_rng;
    logic [W:0]   sum;
    logic [W:0]   lim;

    assign sum = {1'b0, cnt} + {1'b0, add_val};
    assign lim = {1'b1, {W{1'b0}}} - {1'b0, offs};
    assign hit = hit_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            offs   <= '0;
            on     <= 1'b0;
            ovf_q  <= 1'b0;
            hit_q  <= 1'b0;
            in_rng <= 1'b0;
        end else if (ld_we) begin
            offs   <= ~ld_factor + 1'b1;
            cnt    <= ld_residue;
            on     <= ld_on;
            ovf_q  <= 1'b0;
            hit_q  <= 1'b0;
            in_rng <= 1'b0;
        end else if (do_prep && on) begin
            cnt    <= cnt + offs;
            in_rng <= 1'b1;
        end else if (do_add && on) begin
            cnt   <= sum[W-1:0];
            ovf_q <= sum[W];
            hit_q <= sum[W] && (sum[W-1:0] == '0);
        end else if (do_fix) begin
            if (ovf_q) cnt <= cnt + offs;
            ovf_q <= 1'b0;
            hit_q <= 1'b0;
        end
    end

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on && in_rng && !ovf_q) |-> (cnt >= offs));
    // R9
    delta_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_add && on) |-> ({1'b0, add_val} < lim));
    // R3
    carry_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> !ovf_q);
endmodule

// File: rtl/fcsa_seq_ctrl.sv
module fcsa_seq_ctrl
    import fcsa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_arm,
    input  logic in_valid,
    input  logic out_ready,
    input  logic any_hit,
    output logic in_ready,
    output logic out_valid,
    output logic do_prep,
    output logic do_add,
    output logic do_fix,
    output logic can_cfg
);
    fcsa_state_e st, st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (cfg_arm)   st_nx = ST_PREP;
            ST_PREP:                st_nx = ST_RUN;
            ST_RUN:  if (in_valid)  st_nx = ST_FIX;
            ST_FIX:  st_nx = any_hit ? ST_RUN : ST_HOLD;
            ST_HOLD: if (out_ready) st_nx = ST_RUN;
            default:                st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = (st == ST_RUN);
        out_valid = (st == ST_HOLD);
        do_prep   = (st == ST_PREP);
        do_add    = (st == ST_RUN) && in_valid;
        do_fix    = (st == ST_FIX);
        can_cfg   = (st == ST_IDLE);
    end

    // R3
    add_then_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_add |=> (do_fix && !in_ready && !out_valid));
    // R7
    hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);
    // R4
    hit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_fix && any_hit) |=> (!out_valid && in_ready));
endmodule

// File: rtl/fcsa_out_acc.sv
module fcsa_out_acc #(
    parameter int HD_W  = 3,
    parameter int OD_W  = 8,
    parameter int VAL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_we,
    input  logic [VAL_W-1:0] ld_base,
    input  logic [VAL_W-1:0] ld_square,
    input  logic             do_add,
    input  logic [HD_W-1:0]  in_hdelta,
    input  logic             out_take,
    output logic [OD_W-1:0]  out_hdelta,
    output logic             out_prime
);
    logic [VAL_W-1:0] cand;
    logic [VAL_W-1:0] sq;
    logic [OD_W-1:0]  acc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand <= '0;
            sq   <= '0;
            acc  <= '0;
        end else if (ld_we) begin
            cand <= ld_base;
            sq   <= ld_square;
            acc  <= '0;
        end else if (do_add) begin
            cand <= cand + VAL_W'({in_hdelta, 1'b0});
            acc  <= acc + OD_W'(in_hdelta);
        end else if (out_take) begin
            acc  <= '0;
        end
    end

    assign out_hdelta = acc;
    assign out_prime  = (cand < sq);
endmodule

// File: rtl/fcsa_sieve_array.sv
module fcsa_sieve_array #(
    parameter int N_SLOT = 4,
    parameter int CNT_W  = 8,
    parameter int HD_W   = 3,
    parameter int OD_W   = 8,
    parameter int VAL_W  = 12,
    localparam int IW    = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_slot_we,
    input  logic [IW-1:0]    cfg_slot_idx,
    input  logic [CNT_W-1:0] cfg_factor,
    input  logic [CNT_W-1:0] cfg_residue,
    input  logic             cfg_slot_on,
    input  logic             cfg_limit_we,
    input  logic [VAL_W-1:0] cfg_base,
    input  logic [VAL_W-1:0] cfg_square,
    input  logic             cfg_arm,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [HD_W-1:0]  in_hdelta,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OD_W-1:0]  out_hdelta,
    output logic             out_true_prime
);
    logic              do_prep, do_add, do_fix, can_cfg, any_hit;
    logic [N_SLOT-1:0] hits;
    logic [CNT_W-1:0]  add_val;

    assign add_val = CNT_W'({in_hdelta, 1'b0});
    assign any_hit = |hits;

    fcsa_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_arm   (cfg_arm),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .any_hit   (any_hit),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .do_prep   (do_prep),
        .do_add    (do_add),
        .do_fix    (do_fix),
        .can_cfg   (can_cfg)
    );

    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        fcsa_clear_unit #(.W(CNT_W)) u_unit (
            .clk        (clk),
            .rst_n      (rst_n),
            .ld_we      (cfg_slot_we && can_cfg && (cfg_slot_idx == IW'(g))),
            .ld_on      (cfg_slot_on),
            .ld_factor  (cfg_factor),
            .ld_residue (cfg_residue),
            .do_prep    (do_prep),
            .do_add     (do_add),
            .do_fix     (do_fix),
            .add_val    (add_val),
            .hit        (hits[g])
        );
    end

    fcsa_out_acc #(.HD_W(HD_W), .OD_W(OD_W), .VAL_W(VAL_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_we      (cfg_limit_we && can_cfg),
        .ld_base    (cfg_base),
        .ld_square  (cfg_square),
        .do_add     (do_add),
        .in_hdelta  (in_hdelta),
        .out_take   (out_valid && out_ready),
        .out_hdelta (out_hdelta),
        .out_prime  (out_true_prime)
    );

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            ($stable(out_hdelta) && $stable(out_true_prime) && !in_ready));
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        can_cfg |-> (!in_ready && !out_valid));
endmodule

// File: tb/test_fcsa_sieve_array.sv
module test_fcsa_sieve_array;
    localparam int CLK_PERIOD = 10;
    localparam int N_SLOT = 4;
    localparam int CNT_W  = 8;
    localparam int HD_W   = 3;
    localparam int OD_W   = 8;
    localparam int VAL_W  = 12;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cfg_slot_we;
    logic [1:0]       cfg_slot_idx;
    logic [CNT_W-1:0] cfg_factor;
    logic [CNT_W-1:0] cfg_residue;
    logic             cfg_slot_on;
    logic             cfg_limit_we;
    logic [VAL_W-1:0] cfg_base;
    logic [VAL_W-1:0] cfg_square;
    logic             cfg_arm;
    logic             in_valid;
    logic             in_ready;
    logic [HD_W-1:0]  in_hdelta;
    logic             out_valid;
    logic             out_ready;
    logic [OD_W-1:0]  out_hdelta;
    logic             out_true_prime;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fcsa_sieve_array #(
        .N_SLOT(N_SLOT), .CNT_W(CNT_W), .HD_W(HD_W), .OD_W(OD_W), .VAL_W(VAL_W)
    ) i_fcsa_sieve_array (
        .clk(clk), .rst_n(rst_n),
        .cfg_slot_we(cfg_slot_we), .cfg_slot_idx(cfg_slot_idx),
        .cfg_factor(cfg_factor), .cfg_residue(cfg_residue), .cfg_slot_on(cfg_slot_on),
        .cfg_limit_we(cfg_limit_we), .cfg_base(cfg_base), .cfg_square(cfg_square),
        .cfg_arm(cfg_arm),
        .in_valid(in_valid), .in_ready(in_ready), .in_hdelta(in_hdelta),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_hdelta(out_hdelta), .out_true_prime(out_true_prime)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cfg_slot_we = 0; cfg_slot_idx = 0; cfg_factor = 0; cfg_residue = 0;
        cfg_slot_on = 0; cfg_limit_we = 0; cfg_base = 0; cfg_square = 0;
        cfg_arm = 0; in_valid = 0; in_hdelta = 0; out_ready = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One streaming pass: factors 5,7,11,13; mask selects enabled slots.
    task automatic run_pass(input int base, input bit [3:0] mask, input int ncand,
                            input int square, input bit stall);
        int fac[4] = '{5, 7, 11, 13};
        int val;
        int pend;
        for (int k = 0; k < 4; k++) begin
            // R9: residue written as start value modulo factor
            cfg_slot_we = 1; cfg_slot_idx = 2'(k); cfg_factor = CNT_W'(fac[k]);
            cfg_residue = CNT_W'(base % fac[k]); cfg_slot_on = mask[k];
            @(negedge clk);
        end
        cfg_slot_we = 0;
        cfg_limit_we = 1; cfg_base = VAL_W'(base); cfg_square = VAL_W'(square);
        @(negedge clk);
        cfg_limit_we = 0;
        cfg_arm = 1;
        @(negedge clk);
        cfg_arm = 0;
        chk(in_ready == 0, "R2 prep cycle", int'(in_ready), 0);
        @(negedge clk);
        chk(in_ready == 1, "R2 run after prep", int'(in_ready), 1);
        val  = base;
        pend = 0;
        for (int i = 0; i < ncand; i++) begin
            int hd;
            bit surv;
            bit by7;
            hd   = (i % 3 == 2) ? 2 : 1;
            val  += 2 * hd;
            pend += hd;
            surv = 1;
            by7  = 0;
            for (int k = 0; k < 4; k++) begin
                if (val % fac[k] == 0) begin
                    if (mask[k]) surv = 0;
                    else if (k == 1) by7 = 1;
                end
            end
            while (!in_ready) @(negedge clk);
            in_valid = 1; in_hdelta = HD_W'(hd);
            @(negedge clk);
            in_valid = 0;
            chk(in_ready == 0 && out_valid == 0, "R3 fix cycle",
                int'({in_ready, out_valid}), 0);
            @(negedge clk);
            if (surv) begin
                chk(out_valid == 1, by7 ? "R8 disabled slot kept" :
                    (i == 0 ? "R9 first survivor" : "R4 survivor"), int'(out_valid), 1);
                chk(int'(out_hdelta) == pend, "R5 folded delta", int'(out_hdelta), pend);
                chk(out_true_prime == (val < square), "R6 square flag",
                    int'(out_true_prime), int'(val < square));
                if (stall) begin
                    for (int s = 0; s < (i % 3); s++) begin
                        @(negedge clk);
                        chk(out_valid == 1 && int'(out_hdelta) == pend && in_ready == 0,
                            "R7 stall hold", int'(out_hdelta), pend);
                    end
                end
                out_ready = 1;
                @(negedge clk);
                out_ready = 0;
                pend = 0;
                chk(out_valid == 0 && in_ready == 1, "R7 released",
                    int'({out_valid, in_ready}), 1);
            end else begin
                chk(out_valid == 0 && in_ready == 1, "R4 dropped",
                    int'({out_valid, in_ready}), 1);
            end
        end
    endtask

    initial begin
        do_reset();
        // R1: idle after reset, in_valid ignored without arm
        chk(in_ready == 0 && out_valid == 0, "R1 reset state",
            int'({in_ready, out_valid}), 0);
        in_valid = 1; in_hdelta = 1;
        repeat (3) @(negedge clk);
        chk(in_ready == 0 && out_valid == 0, "R1 no arm", int'({in_ready, out_valid}), 0);
        in_valid = 0;
        run_pass(15, 4'b1111, 60, 121, 1'b1);
        do_reset();
        run_pass(41, 4'b1101, 30, 80, 1'b0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule